// File: doc/BRIEF.md
# Write Strobe Capture Front End

This block sits behind the pins of an asynchronous parallel memory port and turns the three active-low control lines (chip enable, output enable, write enable) into clean synchronous events. Every control line, the address bus and the data bus pass through matched multi-stage register chains, so the control edges and the bus values stay aligned cycle for cycle inside the clock domain.

A write strobe exists only while chip enable and write enable are both low and output enable is high. The block takes the address in the first sampled cycle of that strobe, which is the later of the two falling edges. It takes the data in the first sampled cycle after the strobe, which is the earlier of the two rising edges. A strobe that lasts fewer than `MIN_PULSE` sampled cycles is treated as a glitch. Writes are also refused while the digital supply-low flag is set, and for a power-on settling window after that flag clears. Each accepted write leaves the block as one single-cycle pulse carrying the captured address and data. A separate read-enable output tells the pad logic when to drive data out.

Top module: `wstrobe_frontend`

## Requirements
- R1: A write strobe is the condition `oe_n`=1, `ce_n`=0, `we_n`=0 on a sampled cycle. Any other combination, including both enables low with `oe_n`=0, produces no write.
- R2: `wr_addr` carries `addr_in` as sampled in the first cycle of the strobe, whichever of `ce_n` and `we_n` fell last. Address changes later in the strobe are ignored.
- R3: `wr_data` carries `data_in` as sampled in the first cycle after the strobe ends, whichever of `ce_n` and `we_n` rose first.
- R4: A strobe shorter than `MIN_PULSE` sampled cycles produces no write. A strobe of `MIN_PULSE` or more cycles produces exactly one write.
- R5: If `supply_low` is sampled high in any cycle of a strobe, or in the cycle that ends it, the write is dropped.
- R6: After `supply_low` is sampled low, writes stay blocked until `POR_CYCLES`+1 consecutive low samples have been seen. A high sample restarts the wait.
- R7: `wr_valid` is high for exactly one cycle per accepted write. It rises after the second clock edge following the edge that first samples the strobe inactive. Back-to-back strobes separated by a single idle sample each produce their own pulse.
- R8: `rd_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1 were sampled, with the same latency as a write (2 edges after sampling). Otherwise it is 0.
- R9: While `rst_n` is low, `wr_valid`, `rd_en`, `wr_addr` and `wr_data` are 0, and the supply is treated as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr_in | input | ADDR_W | Address bus from the pins |
| data_in | input | DATA_W | Data bus from the pins |
| supply_low | input | 1 | Digital supply-below-threshold flag |
| wr_valid | output | 1 | One-cycle accepted write event |
| wr_addr | output | ADDR_W | Address of the write event |
| wr_data | output | DATA_W | Data of the write event |
| rd_en | output | 1 | Drive read data onto the pins |

## Verification
The bench drives strobes controlled by write enable and by chip enable, changing the address and the data in the middle of each strobe. A design that captured both at one edge would report the wrong address or the wrong data. It sweeps the strobe length across the `MIN_PULSE` boundary, which catches an off-by-one filter that either accepts a glitch or drops a legal pulse. It also holds both enables low while output enable is low, which a strobe that ignores output enable would turn into a write. A supply dip inside a strobe and writes attempted inside the power-on window must produce no event, or the block would write during brown-out. Back-to-back strobes with one idle sample between them must give two separate pulses, not one merged pulse or a stretched one.

// File: rtl/wsf_pkg.sv
package wsf_pkg;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic low;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/stage_delay.sv
module stage_delay #(
    parameter int W        = 1,
    parameter int STAGES   = 2,
    parameter bit RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RST_VAL = {W{RST_ONES}};

    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_comb pipe_d[i] = d;
        end else begin : g_body
            always_comb pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/por_timer.sv
module por_timer #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic ready
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == CNT_MAX) && !hold;
endmodule

// File: rtl/wstrobe_frontend.sv
module wstrobe_frontend #(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 2,
    parameter int POR_CYCLES  = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              supply_low,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en
);
    import wsf_pkg::*;

    localparam int LEN_W = $clog2(MIN_PULSE + 1);
    localparam int BUS_W = ADDR_W + DATA_W;
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_PULSE);

    typedef struct packed {
        logic              prev;
        logic [LEN_W-1:0]  len;
        logic              taint;
        logic [ADDR_W-1:0] acap;
        logic              wv;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
        logic              rd;
    } st_t;

    ctl_t              ctl_raw, ctl_s;
    logic [BUS_W-1:0]  bus_raw, bus_s;
    logic              ready;
    logic              strobe;
    st_t               st_d, st_q;

    assign ctl_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, low: supply_low};
    assign bus_raw = {addr_in, data_in};

    // control lines and supply flag reset to the idle / unsafe level
    stage_delay #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_ONES(1'b1)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
    );

    // bus delayed by the same depth so it lines up with the control edges
    stage_delay #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_ONES(1'b0)) u_bus_dly (
        .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
    );

    por_timer #(.LIMIT(POR_CYCLES)) u_por (
        .clk(clk), .rst_n(rst_n), .hold(ctl_s.low), .ready(ready)
    );

    assign strobe = ctl_s.oe_n & ~ctl_s.ce_n & ~ctl_s.we_n;

    always_comb begin
        st_d      = st_q;
        st_d.wv   = 1'b0;
        st_d.prev = strobe;
        st_d.rd   = ~ctl_s.ce_n & ~ctl_s.oe_n & ctl_s.we_n;
        if (strobe && !st_q.prev) begin
            // later falling edge: strobe opens, take the address
            st_d.len   = LEN_W'(1);
            st_d.taint = !ready;
            st_d.acap  = bus_s[BUS_W-1:DATA_W];
        end else if (strobe) begin
            if (st_q.len != LEN_MIN) st_d.len = st_q.len + 1'b1;
            st_d.taint = st_q.taint | !ready;
        end else if (st_q.prev) begin
            // earlier rising edge: strobe closes, take the data
            if ((st_q.len >= LEN_MIN) && !st_q.taint && ready) begin
                st_d.wv = 1'b1;
                st_d.wa = st_q.acap;
                st_d.wd = bus_s[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_valid = st_q.wv;
    assign wr_addr  = st_q.wa;
    assign wr_data  = st_q.wd;
    assign rd_en    = st_q.rd;
endmodule

// File: rtl/wstrobe_frontend_chk.sv
module wstrobe_frontend_chk #(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter int POR_CYCLES = 1250
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [DATA_W-1:0] data_in,
    input logic              supply_low,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en
);
    localparam int OK_W = $clog2(POR_CYCLES + 2);
    localparam logic [OK_W-1:0] OK_MAX = OK_W'(POR_CYCLES + 1);

    logic            raw_strobe, raw_read;
    logic [OK_W-1:0] ok_cnt;

    assign raw_strobe = oe_n & ~ce_n & ~we_n;
    assign raw_read   = ~ce_n & ~oe_n & we_n;

    // run of consecutive clean supply samples seen at the pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ok_cnt <= '0;
        else if (supply_low)      ok_cnt <= '0;
        else if (ok_cnt != OK_MAX) ok_cnt <= ok_cnt + 1'b1;
    end

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_strobe_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(raw_strobe, 4) && !$past(raw_strobe, 3)));

    assert_supply_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$past(supply_low, 3));

    assert_por_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(ok_cnt, 3) == OK_MAX));

    assert_read_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $past(raw_read, 3));

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |-> (!wr_valid && !rd_en));
endmodule

bind wstrobe_frontend wstrobe_frontend_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POR_CYCLES(POR_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_in(addr_in), .data_in(data_in), .supply_low(supply_low),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en)
);

// File: tb/wstrobe_frontend_bench.sv
module wstrobe_frontend_bench;
    localparam int AW  = 18;
    localparam int DW  = 8;
    localparam int MINP = 2;
    localparam int POR = 1250;

    typedef struct {
        logic          ce_n, oe_n, we_n, low;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } smp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic          wr_valid, rd_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int    checks = 0, fails = 0;
    bit    done = 1'b0;
    string phase = "R9";

    always #4 clk = ~clk;

    wstrobe_frontend #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2),
                       .MIN_PULSE(MINP), .POR_CYCLES(POR)) u_wstrobe_frontend (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr_in(addr_in), .data_in(data_in), .supply_low(supply_low),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en)
    );

    // ---------------- behavioural reference ----------------
    smp_t          hist[$];
    int            good_run = 0, run_len = 0;
    bit            spoiled = 0;
    logic [AW-1:0] open_addr = '0;
    bit            exp_v = 0, exp_rd = 0;
    logic [AW-1:0] exp_a = '0;
    logic [DW-1:0] exp_d = '0;

    function automatic smp_t idle_smp();
        smp_t s;
        s.ce_n = 1; s.oe_n = 1; s.we_n = 1; s.low = 1; s.addr = '0; s.data = '0;
        return s;
    endfunction

    initial begin
        for (int i = 0; i < 3; i++) hist.push_back(idle_smp());
    end

    always @(posedge clk) begin
        smp_t now_s, x, y;
        bit   wx, wy, ok_now;
        now_s.ce_n = ce_n; now_s.oe_n = oe_n; now_s.we_n = we_n;
        now_s.low = supply_low; now_s.addr = addr_in; now_s.data = data_in;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 3; i++) hist.push_back(idle_smp());
            good_run = 0; run_len = 0; spoiled = 0;
            exp_v = 0; exp_rd = 0;
        end else begin
            x = hist[1];
            y = hist[2];
            wx = x.oe_n && !x.ce_n && !x.we_n;
            wy = y.oe_n && !y.ce_n && !y.we_n;
            ok_now = (good_run == POR) && !x.low;
            if (x.low) good_run = 0;
            else if (good_run < POR) good_run++;
            exp_v  = 0;
            exp_rd = !x.ce_n && !x.oe_n && x.we_n;
            if (wx && !wy) begin
                run_len = 1; spoiled = !ok_now; open_addr = x.addr;
            end else if (wx) begin
                run_len++; spoiled = spoiled || !ok_now;
            end else if (wy) begin
                if (run_len >= MINP && !spoiled && ok_now) begin
                    exp_v = 1; exp_a = open_addr; exp_d = x.data;
                end
            end
            hist.push_front(now_s);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (wr_valid !== exp_v || rd_en !== exp_rd) begin
                fails++;
                $display("FAIL %s wr_valid/rd_en got %b/%b exp %b/%b at %0t",
                         phase, wr_valid, rd_en, exp_v, exp_rd, $time);
            end
            if (exp_v) begin
                checks++;
                if (wr_addr !== exp_a || wr_data !== exp_d) begin
                    fails++;
                    $display("FAIL %s addr/data got %h/%h exp %h/%h at %0t",
                             phase, wr_addr, wr_data, exp_a, exp_d, $time);
                end
            end
            if (!rst_n) begin
                checks++;
                if (wr_addr !== '0 || wr_data !== '0) begin
                    fails++;
                    $display("FAIL R9 reset bus got %h/%h exp 0/0", wr_addr, wr_data);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input logic c, input logic o, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input int n);
        ce_n = c; oe_n = o; we_n = w; addr_in = a; data_in = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int len, input logic [AW-1:0] a, input logic [DW-1:0] d);
        put(0, 1, 0, a, d, len);
        put(1, 1, 1, a, d, 4);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired in phase %s", phase);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        phase = "R9";
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        supply_low = 1'b0;

        phase = "R6 early";
        put(1, 1, 1, 0, 0, 5);
        pulse(4, 18'h00100, 8'h11);
        put(1, 1, 1, 0, 0, POR + 10);

        phase = "R1 R2 R3 we-ctl";
        put(0, 1, 1, 18'h3FFF0, 8'hAA, 2);
        put(0, 1, 0, 18'h12345, 8'h0F, 3);
        put(0, 1, 0, 18'h2AAAA, 8'h5C, 2);
        put(0, 1, 1, 18'h2AAAA, 8'h5C, 3);
        put(1, 1, 1, 18'h00000, 8'h00, 5);

        phase = "R1 R2 R3 ce-ctl";
        put(1, 1, 0, 18'h01111, 8'h22, 2);
        put(0, 1, 0, 18'h0ABCD, 8'h33, 3);
        put(0, 1, 0, 18'h15555, 8'hC4, 2);
        put(1, 1, 0, 18'h15555, 8'hC4, 3);
        put(1, 1, 1, 18'h00000, 8'h00, 5);

        phase = "R1 oe low";
        put(0, 0, 0, 18'h00777, 8'h77, 5);
        put(1, 1, 1, 18'h00000, 8'h00, 5);

        phase = "R4";
        for (int len = 1; len <= MINP + 2; len++)
            pulse(len, 18'(len * 18'h101), 8'(len + 8'h40));

        phase = "R7";
        put(0, 1, 0, 18'h00A01, 8'h01, 3);
        put(1, 1, 1, 18'h00A01, 8'h02, 1);
        put(0, 1, 0, 18'h00A02, 8'h03, 3);
        put(1, 1, 1, 18'h00A02, 8'h04, 5);

        phase = "R8";
        put(0, 0, 1, 18'h00055, 8'h00, 4);
        put(0, 1, 1, 18'h00055, 8'h00, 3);
        put(1, 0, 1, 18'h00055, 8'h00, 3);
        put(1, 1, 1, 18'h00000, 8'h00, 4);

        phase = "R5";
        put(0, 1, 0, 18'h00B00, 8'h66, 2);
        supply_low = 1'b1;
        put(0, 1, 0, 18'h00B00, 8'h66, 1);
        supply_low = 1'b0;
        put(0, 1, 0, 18'h00B00, 8'h67, 2);
        put(1, 1, 1, 18'h00B00, 8'h67, 5);

        phase = "R6 restart";
        pulse(4, 18'h00C00, 8'h99);
        put(1, 1, 1, 0, 0, POR - 40);
        pulse(3, 18'h00C01, 8'h9A);
        put(1, 1, 1, 0, 0, 60);
        pulse(3, 18'h00C02, 8'h9B);
        put(1, 1, 1, 0, 0, 6);

        finish_run();
    end
endmodule